// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block sits on a register bus and lets software reach PCI configuration space through two registers. A 64-bit selector register holds an enable flag, a target bus number, a device/function number and a dword-aligned register offset. A narrow data window turns each 1, 2 or 4 byte access into exactly one configuration request on a downstream port. Data moves little-endian on the configuration side and big-endian on the register side, so the bridge reverses the bytes of each access according to its size.

Before it issues a request, the bridge checks three things: the enable flag, whether the target exists, and whether the final offset lies inside the target's configuration space. The downstream side reports existence and space size through a sideband lookup keyed by the selector's bus and device/function. A rejected read returns all ones. A rejected write is dropped. A register access that is neither a data-window access nor an aligned 8-byte access raises an error flag with its response. Only one access is in flight at a time. The host may start an access only while `host_ready` is high.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset `host_ready` is 1, `rsp_valid`, `rsp_err` and `dn_valid` are 0, and the selector register reads as zero.
- R2: An 8-byte, 8-byte-aligned write at `SEL_OFF` sets the selector register, and an 8-byte read there returns it. Other aligned 8-byte offsets outside the window read as zero and ignore writes.
- R3: Selector field positions:
  - bit 63 is the enable;
  - bits 59:52 are the bus;
  - bits 51:44 are the device/function;
  - bits 43:32, masked with 0xFFC and ORed with the low two bits of the access offset, give `dn_offset`.
- R4: With selector bit 63 clear, a window read returns all ones (64 bits) and a window write issues no downstream request.
- R5: An access is a window access when its offset ANDed with 0xFFFC equals `WIN_OFF` and its size is 1, 2 or 4 bytes. The size is given in bytes on `req_size`.
- R6: On a window write, the write data (low `req_size` bytes of `req_wdata`) is byte-swapped by size:
  - 1 byte is unchanged;
  - 2 bytes are exchanged;
  - 4 bytes are fully reversed.
  The result is shifted to byte lane `offset[1:0]` of `dn_wdata`, and `dn_be` marks those lanes.
- R7: On a window read, the bytes in lanes starting at `offset[1:0]` of `dn_rsp_data` are swapped the same way and returned zero-extended on `rsp_rdata`.
- R8: If the final offset is at or above the target's space size (256 when `tgt_ext` is 0, 4096 when it is 1), a read returns all ones and a write issues no request.
- R9: If `tgt_present` is 0 for the selected target, a read returns all ones and a write issues no request.
- R10: Any other register access (wrong size, misalignment, or an 8-byte access to the window) completes with `rsp_err` high, returns all ones and changes no state.
- R11: A downstream request holds `dn_valid` and its fields stable until `dn_ready`. An accepted window access causes exactly one request. A read completes one cycle after `dn_rsp_valid`, and every access yields a single-cycle `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFF_W | Byte offset of the access |
| req_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| req_wdata | input | 64 | Write data, right-aligned |
| host_ready | output | 1 | Bridge idle, request may be presented |
| rsp_valid | output | 1 | Access complete (one cycle) |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Malformed register access |
| tgt_bus | output | 8 | Selector bus, for the existence/size lookup |
| tgt_devfn | output | 8 | Selector device/function, for the lookup |
| tgt_present | input | 1 | Selected target exists |
| tgt_ext | input | 1 | Selected target has a 4096-byte space |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_bus | output | 8 | Request bus number |
| dn_devfn | output | 8 | Request device/function |
| dn_offset | output | 12 | Request byte offset |
| dn_be | output | 4 | Request byte enables |
| dn_write | output | 1 | Request is a write |
| dn_wdata | output | 32 | Request write data, lane-aligned |
| dn_rsp_valid | input | 1 | Read response valid |
| dn_rsp_data | input | 32 | Read response dword |

## Verification
The window is exercised with every size and with several byte lanes. A 4-byte write is followed by 1-, 2- and 4-byte reads of the same dword, which separates a missing swap, a wrong lane shift and a wrong size mask. A single-byte write into a known dword then shows that the byte enables touch only one lane.

The rejection paths are tried one at a time from an otherwise valid selector: a cleared enable, a missing target, offsets on both sides of the 256-byte boundary, and a high offset on an extended target. This shows each check acts alone. Malformed register accesses are followed by a selector read-back to show they changed nothing. A downstream model that stalls `dn_ready` and delays responses exercises the handshake.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    // selector register field positions
    localparam int SEL_EN_BIT    = 63;
    localparam int SEL_BUS_LSB   = 52;
    localparam int SEL_DEVFN_LSB = 44;
    localparam int SEL_OFF_LSB   = 32;
    localparam int BUS_W         = 8;
    localparam int DEVFN_W       = 8;
    localparam int CFG_OFF_W     = 12;

    // configuration space sizes
    localparam int CONV_SPACE = 256;
    localparam int EXT_SPACE  = 4096;

    localparam logic [3:0] SZ_1 = 4'd1;
    localparam logic [3:0] SZ_2 = 4'd2;
    localparam logic [3:0] SZ_4 = 4'd4;
    localparam logic [3:0] SZ_8 = 4'd8;

    typedef enum logic [1:0] {
        ACC_REG = 2'd0,
        ACC_WIN = 2'd1,
        ACC_BAD = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_RESP  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [BUS_W-1:0]     bus;
        logic [DEVFN_W-1:0]   devfn;
        logic [CFG_OFF_W-1:0] offset;
        logic [3:0]           be;
        logic                 write;
        logic [31:0]          data;
    } cfg_req_t;

    typedef struct packed {
        logic                 en;
        logic [BUS_W-1:0]     bus;
        logic [DEVFN_W-1:0]   devfn;
        logic [CFG_OFF_W-1:0] dw_off;
    } sel_fields_t;

    function automatic sel_fields_t split_selector(input logic [63:0] s);
        sel_fields_t f;
        f.en     = s[SEL_EN_BIT];
        f.bus    = s[SEL_BUS_LSB +: BUS_W];
        f.devfn  = s[SEL_DEVFN_LSB +: DEVFN_W];
        f.dw_off = s[SEL_OFF_LSB +: CFG_OFF_W] & 12'hFFC;
        return f;
    endfunction

    // endianness flip limited to the access size
    function automatic logic [31:0] swap_sized(input logic [31:0] d, input logic [3:0] sz);
        logic [31:0] r;
        case (sz)
            SZ_2:    r = {16'h0000, d[7:0], d[15:8]};
            SZ_4:    r = {d[7:0], d[15:8], d[23:16], d[31:24]};
            default: r = {24'h000000, d[7:0]};
        endcase
        return r;
    endfunction

    function automatic logic [3:0] lanes_of(input logic [3:0] sz);
        logic [3:0] m;
        case (sz)
            SZ_2:    m = 4'b0011;
            SZ_4:    m = 4'b1111;
            default: m = 4'b0001;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode
    import cfgb_pkg::*;
#(
    parameter int              OFF_W   = 16,
    parameter logic [OFF_W-1:0] SEL_OFF = 16'h0140,
    parameter logic [OFF_W-1:0] WIN_OFF = 16'h0130
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [3:0]       size,
    output acc_kind_e        kind,
    output logic             is_sel
);
    localparam logic [OFF_W-1:0] WIN_MASK = {{(OFF_W-2){1'b1}}, 2'b00};

    logic win_hit;
    logic narrow;
    logic wide_ok;

    always_comb begin
        win_hit = (offset & WIN_MASK) == WIN_OFF;
        narrow  = (size == SZ_1) || (size == SZ_2) || (size == SZ_4);
        wide_ok = (size == SZ_8) && (offset[2:0] == 3'b000);
        if (win_hit && narrow) begin
            kind = ACC_WIN;
        end else if (!win_hit && wide_ok) begin
            kind = ACC_REG;
        end else begin
            kind = ACC_BAD;
        end
        is_sel = (kind == ACC_REG) && (offset == SEL_OFF);
    end

endmodule

// File: rtl/cfgb_lane.sv
module cfgb_lane
    import cfgb_pkg::*;
#(
    parameter bit TO_DEV = 1'b1
) (
    input  logic [31:0] din,
    input  logic [3:0]  size,
    input  logic [1:0]  lo,
    output logic [31:0] dout,
    output logic [3:0]  be
);
    logic [4:0] shamt;
    assign shamt = {lo, 3'b000};
    assign be    = lanes_of(size) << lo;

    generate
        if (TO_DEV) begin : g_to_dev
            // flip, then move into the addressed byte lanes
            assign dout = swap_sized(din, size) << shamt;
        end else begin : g_from_dev
            // pull the addressed lanes down, then flip
            assign dout = swap_sized(din >> shamt, size);
        end
    endgenerate

endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq
    import cfgb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        imm_go,
    input  logic [63:0] imm_data,
    input  logic        imm_err,
    input  logic        win_go,
    input  cfg_req_t    win_req,
    input  logic [3:0]  win_size,
    input  logic        dn_ready,
    input  logic        dn_rsp_valid,
    input  logic [31:0] rd_conv,
    output logic        dn_valid,
    output cfg_req_t    dn_req,
    output logic [3:0]  hold_size,
    output logic        idle,
    output logic        rsp_valid,
    output logic [63:0] rsp_data,
    output logic        rsp_err
);
    seq_state_e  state_q;
    cfg_req_t    req_q;
    logic [3:0]  size_q;
    logic [63:0] data_q;
    logic        err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            req_q   <= '0;
            size_q  <= SZ_1;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (win_go) begin
                        req_q   <= win_req;
                        size_q  <= win_size;
                        state_q <= SQ_ISSUE;
                    end else if (imm_go) begin
                        data_q  <= imm_data;
                        err_q   <= imm_err;
                        state_q <= SQ_RESP;
                    end
                end
                SQ_ISSUE: begin
                    if (dn_ready) begin
                        if (req_q.write) begin
                            data_q  <= '0;
                            err_q   <= 1'b0;
                            state_q <= SQ_RESP;
                        end else begin
                            state_q <= SQ_WAIT;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (dn_rsp_valid) begin
                        data_q  <= {32'h0, rd_conv};
                        err_q   <= 1'b0;
                        state_q <= SQ_RESP;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign dn_valid  = (state_q == SQ_ISSUE);
    assign dn_req    = req_q;
    assign hold_size = size_q;
    assign idle      = (state_q == SQ_IDLE);
    assign rsp_valid = (state_q == SQ_RESP);
    assign rsp_data  = data_q;
    assign rsp_err   = (state_q == SQ_RESP) && err_q;

    AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_req))) else $error("dn hold"); // R11
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid) else $error("rsp single"); // R11
    AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_data == '1)) else $error("err rsp"); // R10

endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
    import cfgb_pkg::*;
#(
    parameter int               OFF_W   = 16,
    parameter logic [OFF_W-1:0] SEL_OFF = 16'h0140,
    parameter logic [OFF_W-1:0] WIN_OFF = 16'h0130
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [OFF_W-1:0] req_offset,
    input  logic [3:0]       req_size,
    input  logic [63:0]      req_wdata,
    output logic             host_ready,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata,
    output logic             rsp_err,
    output logic [7:0]       tgt_bus,
    output logic [7:0]       tgt_devfn,
    input  logic             tgt_present,
    input  logic             tgt_ext,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [7:0]       dn_bus,
    output logic [7:0]       dn_devfn,
    output logic [11:0]      dn_offset,
    output logic [3:0]       dn_be,
    output logic             dn_write,
    output logic [31:0]      dn_wdata,
    input  logic             dn_rsp_valid,
    input  logic [31:0]      dn_rsp_data
);
    localparam int CONV_TOP_BITS = CFG_OFF_W - $clog2(CONV_SPACE);

    logic [63:0] sel_q;
    sel_fields_t sel;
    acc_kind_e   kind;
    logic        is_sel;
    logic        fire;
    logic [11:0] full_off;
    logic        in_range;
    logic        win_ok;
    logic        win_go;
    logic        imm_go;
    logic [63:0] imm_data;
    logic        imm_err;
    logic [31:0] wr_lane;
    logic [3:0]  wr_be;
    logic [31:0] rd_conv;
    logic [3:0]  rd_be;
    logic [3:0]  hold_size;
    cfg_req_t    new_req;
    cfg_req_t    dn_req;

    assign sel       = split_selector(sel_q);
    assign tgt_bus   = sel.bus;
    assign tgt_devfn = sel.devfn;
    assign fire      = req_valid && host_ready;

    cfgb_decode #(
        .OFF_W   (OFF_W),
        .SEL_OFF (SEL_OFF),
        .WIN_OFF (WIN_OFF)
    ) i_decode (
        .offset (req_offset),
        .size   (req_size),
        .kind   (kind),
        .is_sel (is_sel)
    );

    // final byte offset inside the target's space
    assign full_off = sel.dw_off | {10'h000, req_offset[1:0]};
    assign in_range = tgt_ext || (full_off[CFG_OFF_W-1 -: CONV_TOP_BITS] == '0);
    assign win_ok   = sel.en && tgt_present && in_range;
    assign win_go   = fire && (kind == ACC_WIN) && win_ok;
    assign imm_go   = fire && !win_go;

    cfgb_lane #(.TO_DEV(1'b1)) i_lane_wr (
        .din  (req_wdata[31:0]),
        .size (req_size),
        .lo   (req_offset[1:0]),
        .dout (wr_lane),
        .be   (wr_be)
    );

    always_comb begin
        new_req.bus    = sel.bus;
        new_req.devfn  = sel.devfn;
        new_req.offset = full_off;
        new_req.be     = wr_be;
        new_req.write  = req_write;
        new_req.data   = req_write ? wr_lane : 32'h0;
    end

    // immediate responses: selector access, other registers, rejected window, errors
    always_comb begin
        imm_err  = 1'b0;
        imm_data = '0;
        case (kind)
            ACC_REG: imm_data = (is_sel && !req_write) ? sel_q : '0;
            ACC_WIN: imm_data = req_write ? '0 : '1;
            default: begin
                imm_err  = 1'b1;
                imm_data = '1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (fire && is_sel && req_write) begin
            sel_q <= req_wdata;
        end
    end

    cfgb_seq i_seq (
        .clk          (clk),
        .rst          (rst),
        .imm_go       (imm_go),
        .imm_data     (imm_data),
        .imm_err      (imm_err),
        .win_go       (win_go),
        .win_req      (new_req),
        .win_size     (req_size),
        .dn_ready     (dn_ready),
        .dn_rsp_valid (dn_rsp_valid),
        .rd_conv      (rd_conv),
        .dn_valid     (dn_valid),
        .dn_req       (dn_req),
        .hold_size    (hold_size),
        .idle         (host_ready),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_rdata),
        .rsp_err      (rsp_err)
    );

    cfgb_lane #(.TO_DEV(1'b0)) i_lane_rd (
        .din  (dn_rsp_data),
        .size (hold_size),
        .lo   (dn_req.offset[1:0]),
        .dout (rd_conv),
        .be   (rd_be)
    );

    assign dn_bus    = dn_req.bus;
    assign dn_devfn  = dn_req.devfn;
    assign dn_offset = dn_req.offset;
    assign dn_be     = dn_req.be;
    assign dn_write  = dn_req.write;
    assign dn_wdata  = dn_req.data;

    AST_DN_ENABLED: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> sel_q[SEL_EN_BIT]) else $error("dn while disabled"); // R4
    AST_DN_PRESENT: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> tgt_present) else $error("dn to absent target"); // R9
    AST_DN_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (tgt_ext || dn_offset < 12'(CONV_SPACE))) else $error("dn out of range"); // R8
    AST_LANE_AGREE: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> (dn_be == rd_be && dn_be != 4'h0)) else $error("lane mismatch"); // R6
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        fire |=> !host_ready) else $error("not busy"); // R11
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (fire && kind == ACC_BAD) |=> $stable(sel_q)) else $error("sel changed on bad"); // R10

endmodule

// File: tb/test_cfg_window_bridge.sv
module test_cfg_window_bridge;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SEL = 16'h0140;
    localparam logic [15:0] WIN = 16'h0130;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_offset = '0;
    logic [3:0]  req_size = 4'd8;
    logic [63:0] req_wdata = '0;
    logic        host_ready, rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [7:0]  tgt_bus, tgt_devfn;
    logic        tgt_present, tgt_ext;
    logic        dn_valid, dn_ready, dn_write;
    logic [7:0]  dn_bus, dn_devfn;
    logic [11:0] dn_offset;
    logic [3:0]  dn_be;
    logic [31:0] dn_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rsp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_window_bridge i_cfg_window_bridge (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .host_ready(host_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .tgt_bus(tgt_bus), .tgt_devfn(tgt_devfn),
        .tgt_present(tgt_present), .tgt_ext(tgt_ext), .dn_valid(dn_valid),
        .dn_ready(dn_ready), .dn_bus(dn_bus), .dn_devfn(dn_devfn),
        .dn_offset(dn_offset), .dn_be(dn_be), .dn_write(dn_write),
        .dn_wdata(dn_wdata), .dn_rsp_valid(dn_rsp_valid), .dn_rsp_data(dn_rsp_data)
    );

    // downstream device model: bus 1 devfn 0x00 conventional, devfn 0x08 extended
    logic [31:0] conv_mem [64];
    logic [31:0] ext_mem [1024];
    logic [1:0]  cyc = '0;
    logic        rd_pend = 1'b0;
    logic [31:0] rd_word = '0;
    int          fires = 0;
    logic [7:0]  last_bus, last_devfn;
    logic [11:0] last_off;
    logic [3:0]  last_be;
    logic        last_wr;
    logic [31:0] last_data;

    assign tgt_present = (tgt_bus == 8'd1) && (tgt_devfn == 8'h00 || tgt_devfn == 8'h08);
    assign tgt_ext     = (tgt_bus == 8'd1) && (tgt_devfn == 8'h08);
    assign dn_ready    = (cyc != 2'd3);

    initial begin
        for (int i = 0; i < 64; i++) conv_mem[i] = 32'hA5000000 | i;
        for (int i = 0; i < 1024; i++) ext_mem[i] = '0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 2'd1;
        dn_rsp_valid <= rd_pend;
        dn_rsp_data  <= rd_word;
        rd_pend      <= 1'b0;
        if (dn_valid && dn_ready) begin
            fires = fires + 1;
            last_bus = dn_bus; last_devfn = dn_devfn; last_off = dn_offset;
            last_be = dn_be; last_wr = dn_write; last_data = dn_wdata;
            if (dn_write) begin
                for (int b = 0; b < 4; b++) begin
                    if (dn_be[b]) begin
                        if (dn_devfn == 8'h08) ext_mem[dn_offset[11:2]][b*8 +: 8] = dn_wdata[b*8 +: 8];
                        else conv_mem[dn_offset[7:2]][b*8 +: 8] = dn_wdata[b*8 +: 8];
                    end
                end
            end else begin
                rd_pend <= 1'b1;
                rd_word <= (dn_devfn == 8'h08) ? ext_mem[dn_offset[11:2]] : conv_mem[dn_offset[7:2]];
            end
        end
    end

    // scoreboard
    typedef struct {
        logic [63:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected response", rsp_rdata, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_rdata == e.data, e.tag, rsp_rdata, e.data);
                chk(rsp_err == e.err, {e.tag, " err"}, {63'h0, rsp_err}, {63'h0, e.err});
            end
        end
    end

    task automatic access(input bit wr, input logic [15:0] off, input logic [3:0] sz,
                          input logic [63:0] wd, input logic [63:0] exp, input bit exp_err,
                          input string tag);
        exp_t e;
        e.data = exp; e.err = exp_err; e.tag = tag;
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_offset = off; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!(host_ready && exp_q.size() == 0)) @(negedge clk);
    endtask

    function automatic logic [63:0] mk_sel(input bit en, input logic [7:0] bus,
                                          input logic [7:0] devfn, input logic [11:0] off);
        return {en, 3'b000, bus, devfn, off, 32'h0};
    endfunction

    function automatic logic [31:0] rev32(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    initial begin
        int f0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(host_ready && !rsp_valid && !rsp_err && !dn_valid, "R1 reset outputs",
            {60'h0, host_ready, rsp_valid, rsp_err, dn_valid}, 64'h8);
        access(0, SEL, 4'd8, '0, 64'h0, 0, "R1 selector after reset");

        access(1, SEL, 4'd8, mk_sel(1, 8'd1, 8'h00, 12'h013), 64'h0, 0, "R2 selector write");
        access(0, SEL, 4'd8, '0, mk_sel(1, 8'd1, 8'h00, 12'h013), 0, "R2 selector readback");
        access(1, 16'h0148, 4'd8, 64'hFFFF, 64'h0, 0, "R2 other register write");
        access(0, 16'h0148, 4'd8, '0, 64'h0, 0, "R2 other register reads zero");

        // R3: offset field masked, low bits from access offset
        access(1, WIN + 16'd2, 4'd2, 64'hABCD, 64'h0, 0, "R3 window write");
        chk({last_bus, last_devfn, last_off} == {8'd1, 8'h00, 12'h012}, "R3 target fields",
            {36'h0, last_bus, last_devfn, last_off}, {36'h0, 8'd1, 8'h00, 12'h012});
        chk({last_wr, last_be, last_data} == {1'b1, 4'b1100, 32'hCDAB0000}, "R6 2-byte lanes",
            {27'h0, last_wr, last_be, last_data}, {27'h0, 1'b1, 4'b1100, 32'hCDAB0000});

        access(1, SEL, 4'd8, mk_sel(1, 8'd1, 8'h00, 12'h010), 64'h0, 0, "R2 selector write");
        f0 = fires;
        access(1, WIN, 4'd4, 64'h11223344, 64'h0, 0, "R6 4-byte write");
        chk(fires == f0 + 1, "R11 one request per access", 64'(fires), 64'(f0 + 1));
        chk(conv_mem[4] == 32'h44332211, "R6 4-byte reversed", {32'h0, conv_mem[4]}, 64'h44332211);
        access(0, WIN, 4'd4, '0, 64'h11223344, 0, "R7 4-byte read");
        access(0, WIN + 16'd2, 4'd2, '0, 64'h3344, 0, "R7 2-byte read upper lanes");
        access(0, WIN + 16'd1, 4'd1, '0, 64'h22, 0, "R7 1-byte read lane 1");
        access(0, WIN + 16'd3, 4'd1, '0, 64'h44, 0, "R5 window alias lane 3");
        access(1, WIN + 16'd1, 4'd1, 64'h5A, 64'h0, 0, "R6 1-byte write");
        chk(conv_mem[4] == 32'h44335A11, "R6 single lane", {32'h0, conv_mem[4]}, 64'h44335A11);
        access(0, WIN, 4'd4, '0, 64'h115A3344, 0, "R7 read after byte write");

        // R4 disabled
        access(1, SEL, 4'd8, mk_sel(0, 8'd1, 8'h00, 12'h010), 64'h0, 0, "R4 selector off");
        f0 = fires;
        access(1, WIN, 4'd4, 64'h0BADF00D, 64'h0, 0, "R4 write disabled");
        access(0, WIN, 4'd4, '0, '1, 0, "R4 read disabled all ones");
        chk(fires == f0, "R4 no request", 64'(fires), 64'(f0));

        // R9 absent
        access(1, SEL, 4'd8, mk_sel(1, 8'd2, 8'h00, 12'h010), 64'h0, 0, "R9 selector");
        f0 = fires;
        access(1, WIN, 4'd4, 64'h0BADF00D, 64'h0, 0, "R9 write absent");
        access(0, WIN, 4'd4, '0, '1, 0, "R9 read absent all ones");
        chk(fires == f0, "R9 no request", 64'(fires), 64'(f0));

        // R8 limits
        access(1, SEL, 4'd8, mk_sel(1, 8'd1, 8'h00, 12'h100), 64'h0, 0, "R8 selector");
        f0 = fires;
        access(1, WIN, 4'd4, 64'h0BADF00D, 64'h0, 0, "R8 write beyond 256");
        access(0, WIN, 4'd4, '0, '1, 0, "R8 read beyond 256");
        chk(fires == f0, "R8 no request", 64'(fires), 64'(f0));
        access(1, SEL, 4'd8, mk_sel(1, 8'd1, 8'h00, 12'h0FC), 64'h0, 0, "R8 selector");
        access(0, WIN, 4'd4, '0, {32'h0, rev32(32'hA500003F)}, 0, "R8 last dword inside");
        access(1, SEL, 4'd8, mk_sel(1, 8'd1, 8'h08, 12'h800), 64'h0, 0, "R8 selector ext");
        access(1, WIN, 4'd4, 64'hDEADBEEF, 64'h0, 0, "R8 extended write");
        chk(ext_mem[12'h800 >> 2] == 32'hEFBEADDE, "R8 extended stored",
            {32'h0, ext_mem[12'h800 >> 2]}, 64'hEFBEADDE);
        access(0, WIN, 4'd4, '0, 64'hDEADBEEF, 0, "R8 extended read");

        // R10 malformed
        access(1, SEL, 4'd4, 64'h1234, '1, 1, "R10 short selector write");
        access(1, SEL + 16'd4, 4'd8, 64'h1234, '1, 1, "R10 misaligned write");
        access(0, WIN, 4'd8, '0, '1, 1, "R10 wide window read");
        access(0, SEL, 4'd3, '0, '1, 1, "R10 odd size read");
        access(0, SEL, 4'd8, '0, mk_sel(1, 8'd1, 8'h08, 12'h800), 0, "R10 selector unchanged");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule